// File: doc/BRIEF.md
# Peripheral Protection Control Register Bank

This block holds the configuration that a set of peripheral protection controllers use to gate their downstream ports. Each controller has three per-port masks: a non-secure mask, a privilege mask applied to secure accesses and a privilege mask applied to non-secure accesses. The non-secure mask drives one nonsec line per port. A per-port access-privilege line is a live selection between the two privilege masks, steered by that port's non-secure bit. Two small configuration registers are also held here: a 2-bit non-secure-callable setting and a 1-bit secure-response setting. Each drives output lines of its own.

Software reaches the bank through two 4 KB register windows on one simple single-cycle bus. An input bit picks the window. The secure window owns the non-secure masks, the secure privilege masks and the configuration registers. The non-secure window can only write the non-secure privilege masks. Both windows serve constant identification bytes, read-as-zero placeholder words and byte or halfword reads.

The controllers are numbered in one flat list. Internal peripheral-bus controllers come first (default 2, 4 ports each). Expansion peripheral-bus controllers follow (default 4, 16 ports each), then expansion system-bus controllers (default 4, 16 ports each). Controller p drives output lanes p*16 to p*16+15 of the per-port vectors.

Top module: `ppc_ctl_regs`

## Requirements
- R1: After reset every mask and both configuration registers are zero, so all nonsec, privilege and configuration outputs are 0 and every mask register reads 0.
- R2: Address bits [7:4] select a register group and address bits [3:2] select the controller within it. In the secure window a word write sets the non-secure mask of the following controllers: internal controller 0/1 at 0x70/0x74, expansion peripheral-bus controller k (list index 2+k) at 0x80+4k, and expansion system-bus controller k (list index 6+k) at 0x60+4k. The secure privilege masks use the same controllers at 0xB0/0xB4, 0xC0+4k and 0xA0+4k.
- R3: In the non-secure window the non-secure privilege masks sit at 0xB0/0xB4, 0xC0+4k and 0xA0+4k. No other offset in that window changes any state. Offsets 0x60–0x8C, 0x10 and 0x14 read as zero there.
- R4: The privilege output of port i equals bit i of the non-secure privilege mask when non-secure bit i is 1. Otherwise it equals bit i of the secure privilege mask.
- R5: The nonsec output of port i equals bit i of the stored non-secure mask, and is updated at the clock edge that accepts the write.
- R6: Every mask write keeps only the controller's port count of low bits (4 for internal, 16 for expansion controllers). The rest are stored as zero and read as zero.
- R7: In the secure window offset 0x10 holds the secure-response bit (write data bit 0) and offset 0x14 holds the 2-bit non-secure-callable value (write data bits 1:0). Each drives its output directly. Non-secure-window accesses to these offsets have no effect.
- R8: The placeholder word at 0x50 (secure window) and 0x90 (both windows) reads zero and ignores writes.
- R9: A write is accepted only with size code 2 (word). Size codes 0 (byte), 1 (halfword) and 3 leave all state unchanged.
- R10: A read with size code 0 returns byte lane addr[1:0] of the word in bits 7:0. Size code 1 returns bits 15:0 of the word shifted right by 8*addr[1:0]. The other bits are zero, and codes 2 and 3 return the whole word.
- R11: Offsets 0xFD0–0xFFC read one constant byte each, in word order: 04 00 00 00 6A C7 1B 00 0D F0 05 B1. The only difference in the non-secure window is that 0xFE0 reads 6B.
- R12: Unmapped offsets read zero and ignore writes. The read data is zero in any cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_nswin | input | 1 | 1 = non-secure window, 0 = secure window |
| bus_addr | input | 12 | Byte offset inside the window |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word (3 read as word, never written) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| ppc_nonsec | output | 160 | Per-port nonsec lines, controller p at lanes p*16+i |
| ppc_priv | output | 160 | Per-port access-privilege lines, same lane layout |
| nsc_cfg | output | 2 | Non-secure-callable configuration value |
| resp_cfg | output | 1 | Secure-response configuration bit |

## Verification
The privilege mux is tried with the non-secure mask, the secure privilege mask and the non-secure privilege mask all set to different bit patterns on the same controller. Each port lane can then only match if the correct mask was chosen by its own non-secure bit. Writes of all-ones to internal and expansion controllers show whether truncation uses the right port count for each controller kind. Mask writes attempted through the non-secure window, narrow writes, and writes to placeholders and unmapped offsets must leave every output and readback unchanged. A long stretch of random window, offset, size and data traffic, compared against a bench model, catches crossed controller indices and wrong byte-lane selection.

// File: rtl/ppcreg_pkg.sv
package ppcreg_pkg;

  localparam int ADDR_W = 12;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ZERO,
    SEL_RESP,
    SEL_NSC,
    SEL_NS,
    SEL_SP,
    SEL_NSP,
    SEL_ID
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [3:0] ppc;
    logic [3:0] id_idx;
  } dec_t;

  // constant identification bytes; only slot 4 depends on the window
  function automatic logic [7:0] id_byte(input logic nswin, input logic [3:0] idx,
                                         input logic [7:0] part_s,
                                         input logic [7:0] part_ns);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h04;
      4'd4:    b = nswin ? part_ns : part_s;
      4'd5:    b = 8'hC7;
      4'd6:    b = 8'h1B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ppcreg_decode.sv
module ppcreg_decode
  import ppcreg_pkg::*;
#(
  parameter int NUM_INT = 2,
  parameter int NUM_APB = 4,
  parameter int NUM_AHB = 4
) (
  input  logic              nswin,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int APB_BASE = NUM_INT;
  localparam int AHB_BASE = NUM_INT + NUM_APB;

  logic [3:0] grp;
  logic [1:0] sub;
  logic [9:0] id_word;

  assign grp     = addr[7:4];
  assign sub     = addr[3:2];
  assign id_word = addr[11:2] - 10'h3F4;

  always_comb begin
    dec = '{sel: SEL_NONE, ppc: 4'd0, id_idx: 4'd0};
    if (addr[11:4] >= 8'hFD) begin
      dec.sel    = SEL_ID;
      dec.id_idx = id_word[3:0];
    end else if (addr[11:8] == 4'h0) begin
      case (grp)
        4'h1: if (!nswin) dec.sel = (sub == 2'd0) ? SEL_RESP :
                                    (sub == 2'd1) ? SEL_NSC : SEL_NONE;
        4'h5: if (!nswin && sub == 2'd0) dec.sel = SEL_ZERO;
        4'h9: if (sub == 2'd0) dec.sel = SEL_ZERO;
        4'h6: if (!nswin && 32'(sub) < NUM_AHB) begin
          dec.sel = SEL_NS;  dec.ppc = 4'(AHB_BASE) + 4'(sub);
        end
        4'h7: if (!nswin && 32'(sub) < NUM_INT) begin
          dec.sel = SEL_NS;  dec.ppc = 4'(sub);
        end
        4'h8: if (!nswin && 32'(sub) < NUM_APB) begin
          dec.sel = SEL_NS;  dec.ppc = 4'(APB_BASE) + 4'(sub);
        end
        4'hA: if (32'(sub) < NUM_AHB) begin
          dec.sel = nswin ? SEL_NSP : SEL_SP;  dec.ppc = 4'(AHB_BASE) + 4'(sub);
        end
        4'hB: if (32'(sub) < NUM_INT) begin
          dec.sel = nswin ? SEL_NSP : SEL_SP;  dec.ppc = 4'(sub);
        end
        4'hC: if (32'(sub) < NUM_APB) begin
          dec.sel = nswin ? SEL_NSP : SEL_SP;  dec.ppc = 4'(APB_BASE) + 4'(sub);
        end
        default: dec.sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/ppcreg_slice.sv
module ppcreg_slice #(
  parameter int PORTS = 16,
  parameter int MAXP  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ns,
  input  logic            wr_sp,
  input  logic            wr_nsp,
  input  logic [MAXP-1:0] wdata,
  output logic [MAXP-1:0] ns_q,
  output logic [MAXP-1:0] sp_q,
  output logic [MAXP-1:0] nsp_q,
  output logic [MAXP-1:0] priv
);
  localparam logic [MAXP-1:0] KEEP =
    (PORTS >= MAXP) ? {MAXP{1'b1}} : MAXP'((64'd1 << PORTS) - 64'd1);

  logic [MAXP-1:0] ns_d, sp_d, nsp_d;

  always_comb begin
    ns_d  = wr_ns  ? (wdata & KEEP) : ns_q;
    sp_d  = wr_sp  ? (wdata & KEEP) : sp_q;
    nsp_d = wr_nsp ? (wdata & KEEP) : nsp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sp_q  <= '0;
      nsp_q <= '0;
    end else begin
      ns_q  <= ns_d;
      sp_q  <= sp_d;
      nsp_q <= nsp_d;
    end
  end

  // per-port privilege: non-secure bit steers which mask applies
  assign priv = (ns_q & nsp_q) | (~ns_q & sp_q);

endmodule

// File: rtl/ppc_ctl_regs.sv
module ppc_ctl_regs
  import ppcreg_pkg::*;
#(
  parameter int         NUM_INT   = 2,
  parameter int         NUM_APB   = 4,
  parameter int         NUM_AHB   = 4,
  parameter int         INT_PORTS = 4,
  parameter int         EXP_PORTS = 16,
  parameter logic [7:0] PART_S    = 8'h6A,
  parameter logic [7:0] PART_NS   = 8'h6B,
  localparam int        NPPC      = NUM_INT + NUM_APB + NUM_AHB,
  localparam int        MAXP      = (INT_PORTS > EXP_PORTS) ? INT_PORTS : EXP_PORTS,
  localparam int        OUT_W     = NPPC * MAXP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_nswin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [OUT_W-1:0]  ppc_nonsec,
  output logic [OUT_W-1:0]  ppc_priv,
  output logic [1:0]        nsc_cfg,
  output logic              resp_cfg
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dec_t dec;
  ppcreg_decode #(.NUM_INT(NUM_INT), .NUM_APB(NUM_APB), .NUM_AHB(NUM_AHB)) u_dec (
    .nswin (bus_nswin),
    .addr  (bus_addr),
    .dec   (dec)
  );

  logic wr_ok;
  assign wr_ok = bus_valid && bus_write && (bus_size == SZ_WORD);

  logic [MAXP-1:0] ns_arr  [NPPC];
  logic [MAXP-1:0] sp_arr  [NPPC];
  logic [MAXP-1:0] nsp_arr [NPPC];

  for (genvar p = 0; p < NPPC; p++) begin : g_ppc
    logic wr_ns, wr_sp, wr_nsp;
    assign wr_ns  = wr_ok && (dec.sel == SEL_NS)  && (dec.ppc == 4'(p));
    assign wr_sp  = wr_ok && (dec.sel == SEL_SP)  && (dec.ppc == 4'(p));
    assign wr_nsp = wr_ok && (dec.sel == SEL_NSP) && (dec.ppc == 4'(p));

    ppcreg_slice #(.PORTS((p < NUM_INT) ? INT_PORTS : EXP_PORTS), .MAXP(MAXP)) u_slice (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_ns  (wr_ns),
      .wr_sp  (wr_sp),
      .wr_nsp (wr_nsp),
      .wdata  (bus_wdata[MAXP-1:0]),
      .ns_q   (ns_arr[p]),
      .sp_q   (sp_arr[p]),
      .nsp_q  (nsp_arr[p]),
      .priv   (ppc_priv[p*MAXP +: MAXP])
    );
    assign ppc_nonsec[p*MAXP +: MAXP] = ns_arr[p];
  end

  // configuration registers
  logic       resp_q, resp_d;
  logic [1:0] nsc_q, nsc_d;

  always_comb begin
    resp_d = (wr_ok && dec.sel == SEL_RESP) ? bus_wdata[0]   : resp_q;
    nsc_d  = (wr_ok && dec.sel == SEL_NSC)  ? bus_wdata[1:0] : nsc_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      resp_q <= 1'b0;
      nsc_q  <= 2'b00;
    end else begin
      resp_q <= resp_d;
      nsc_q  <= nsc_d;
    end
  end

  assign resp_cfg = resp_q;
  assign nsc_cfg  = nsc_q;

  // read path
  logic [31:0] word, shifted;
  always_comb begin
    word = '0;
    case (dec.sel)
      SEL_RESP: word = {31'b0, resp_q};
      SEL_NSC:  word = {30'b0, nsc_q};
      SEL_ID:   word = {24'b0, id_byte(bus_nswin, dec.id_idx, PART_S, PART_NS)};
      SEL_NS, SEL_SP, SEL_NSP: begin
        for (int k = 0; k < NPPC; k++) begin
          if (dec.ppc == 4'(k)) begin
            word = (dec.sel == SEL_NS) ? 32'(ns_arr[k]) :
                   (dec.sel == SEL_SP) ? 32'(sp_arr[k]) : 32'(nsp_arr[k]);
          end
        end
      end
      default:  word = '0;
    endcase
  end

  assign shifted = word >> {bus_addr[1:0], 3'b000};

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (bus_size)
        SZ_BYTE: bus_rdata = {24'b0, shifted[7:0]};
        SZ_HALF: bus_rdata = {16'b0, shifted[15:0]};
        default: bus_rdata = word;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = &{1'b0, bus_wdata[31:MAXP]};

endmodule

// File: rtl/ppcreg_chk.sv
module ppcreg_chk #(
  parameter int OUT_W = 160
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             bus_valid,
  input logic             bus_write,
  input logic             bus_nswin,
  input logic [9:0]       word_addr,
  input logic [1:0]       bus_size,
  input logic [1:0]       wdata_lo,
  input logic [31:0]      bus_rdata,
  input logic [OUT_W-1:0] ppc_nonsec,
  input logic [OUT_W-1:0] ppc_priv,
  input logic [1:0]       nsc_cfg,
  input logic             resp_cfg
);
  logic do_wr, do_rd;
  assign do_wr = bus_valid && bus_write;
  assign do_rd = bus_valid && !bus_write;

  // R9: narrow writes change nothing
  assert_narrow_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (do_wr && bus_size != 2'd2) |=> ($stable(ppc_nonsec) && $stable(ppc_priv) &&
                                     $stable(nsc_cfg) && $stable(resp_cfg)));

  // R3: the non-secure window never alters nonsec lines or configuration
  assert_nswin_no_nonsec_change_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (do_wr && bus_nswin) |=> ($stable(ppc_nonsec) && $stable(nsc_cfg) && $stable(resp_cfg)));

  // R12: without a write, all held state stays put
  assert_idle_outputs_stable_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    !do_wr |=> ($stable(ppc_nonsec) && $stable(ppc_priv) &&
                $stable(nsc_cfg) && $stable(resp_cfg)));

  // R12: read data is zero outside read requests
  assert_rdata_quiet_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    !do_rd |-> (bus_rdata == 32'h0));

  // R8: placeholder words read zero
  assert_placeholder_zero_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (do_rd && (word_addr == 10'h24 || (!bus_nswin && word_addr == 10'h14)))
      |-> (bus_rdata == 32'h0));

  // R10: sub-word reads are zero-extended
  assert_byte_read_width_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (do_rd && bus_size == 2'd0) |-> (bus_rdata[31:8] == 24'h0));
  assert_half_read_width_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (do_rd && bus_size == 2'd1) |-> (bus_rdata[31:16] == 16'h0));

  // R7: secure word write to the callable setting lands on the output
  assert_nsc_write_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (do_wr && !bus_nswin && bus_size == 2'd2 && word_addr == 10'h05)
      |=> (nsc_cfg == $past(wdata_lo)));
  assert_resp_write_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (do_wr && !bus_nswin && bus_size == 2'd2 && word_addr == 10'h04)
      |=> (resp_cfg == $past(wdata_lo[0])));

endmodule

bind ppc_ctl_regs ppcreg_chk #(.OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_nswin  (bus_nswin),
  .word_addr  (bus_addr[11:2]),
  .bus_size   (bus_size),
  .wdata_lo   (bus_wdata[1:0]),
  .bus_rdata  (bus_rdata),
  .ppc_nonsec (ppc_nonsec),
  .ppc_priv   (ppc_priv),
  .nsc_cfg    (nsc_cfg),
  .resp_cfg   (resp_cfg)
);

// File: tb/tb_ppc_ctl_regs.sv
`timescale 1ns/1ps
module tb_ppc_ctl_regs;

  localparam int NP = 10;
  localparam int W  = NP * 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_write, bus_nswin;
  logic [11:0]   bus_addr;
  logic [1:0]    bus_size;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [W-1:0]  ppc_nonsec, ppc_priv;
  logic [1:0]    nsc_cfg;
  logic          resp_cfg;

  ppc_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_nswin(bus_nswin), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ppc_nonsec(ppc_nonsec),
    .ppc_priv(ppc_priv), .nsc_cfg(nsc_cfg), .resp_cfg(resp_cfg)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // bench model
  logic [15:0] m_ns [NP];
  logic [15:0] m_sp [NP];
  logic [15:0] m_nsp[NP];
  logic        m_resp;
  logic [1:0]  m_nsc;

  function automatic logic [7:0] id_exp(bit nsw, int idx);
    case (idx)
      0: return 8'h04;   4: return nsw ? 8'h6B : 8'h6A;
      5: return 8'hC7;   6: return 8'h1B;
      8: return 8'h0D;   9: return 8'hF0;
      10: return 8'h05;  11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  // which mask a word offset addresses: kind 0 none, 1 ns, 2 sp, 3 nsp; idx = controller
  function automatic void map_mask(bit nsw, logic [11:0] a, output int kind, output int idx);
    int s;
    s = int'(a[3:2]); kind = 0; idx = 0;
    if (a[11:8] != 4'h0) return;
    case (a[7:4])
      4'h6: if (!nsw)          begin kind = 1; idx = 6 + s; end
      4'h7: if (!nsw && s < 2) begin kind = 1; idx = s;     end
      4'h8: if (!nsw)          begin kind = 1; idx = 2 + s; end
      4'hA:                    begin kind = nsw ? 3 : 2; idx = 6 + s; end
      4'hB: if (s < 2)         begin kind = nsw ? 3 : 2; idx = s;     end
      4'hC:                    begin kind = nsw ? 3 : 2; idx = 2 + s; end
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] exp_word(bit nsw, logic [11:0] a);
    int kind, idx;
    if (a >= 12'hFD0) return {24'h0, id_exp(nsw, int'(a[11:2]) - 'h3F4)};
    if (!nsw && a[11:2] == 10'h04) return {31'h0, m_resp};
    if (!nsw && a[11:2] == 10'h05) return {30'h0, m_nsc};
    map_mask(nsw, a, kind, idx);
    case (kind)
      1: return {16'h0, m_ns[idx]};
      2: return {16'h0, m_sp[idx]};
      3: return {16'h0, m_nsp[idx]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(bit nsw, logic [11:0] a, logic [1:0] sz);
    logic [31:0] w;
    w = exp_word(nsw, a) >> (8 * int'(a[1:0]));
    if (sz == 2'd0) return {24'h0, w[7:0]};
    if (sz == 2'd1) return {16'h0, w[15:0]};
    return exp_word(nsw, a);
  endfunction

  task automatic model_write(bit nsw, logic [11:0] a, logic [1:0] sz, logic [31:0] d);
    int kind, idx;
    logic [15:0] keep;
    if (sz != 2'd2) return;
    if (!nsw && a[11:2] == 10'h04) begin m_resp = d[0]; return; end
    if (!nsw && a[11:2] == 10'h05) begin m_nsc = d[1:0]; return; end
    map_mask(nsw, a, kind, idx);
    keep = (idx < 2) ? 16'h000F : 16'hFFFF;
    case (kind)
      1: m_ns[idx]  = d[15:0] & keep;
      2: m_sp[idx]  = d[15:0] & keep;
      3: m_nsp[idx] = d[15:0] & keep;
      default: ;
    endcase
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    logic [W-1:0] e_ns, e_pv;
    for (int p = 0; p < NP; p++) begin
      for (int i = 0; i < 16; i++) begin
        e_ns[p*16+i] = m_ns[p][i];
        e_pv[p*16+i] = m_ns[p][i] ? m_nsp[p][i] : m_sp[p][i];
      end
    end
    check({req, " nonsec"}, W'(ppc_nonsec), e_ns);
    check({req, " priv"}, W'(ppc_priv), e_pv);
    check({req, " cfg"}, W'({resp_cfg, nsc_cfg}), W'({m_resp, m_nsc}));
  endtask

  task automatic bus_op(bit nsw, bit wr, logic [11:0] a, logic [1:0] sz,
                        logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_nswin = nsw;
    bus_addr = a; bus_size = sz; bus_wdata = d;
    #1 rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
    if (wr) model_write(nsw, a, sz, d);
  endtask

  task automatic wr(bit nsw, logic [11:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    logic [31:0] unused_rd;
    bus_op(nsw, 1'b1, a, sz, d, unused_rd);
  endtask

  task automatic rd_check(string req, bit nsw, logic [11:0] a, logic [1:0] sz = 2'd2);
    logic [31:0] r;
    bus_op(nsw, 1'b0, a, sz, 32'h0, r);
    check(req, W'(r), W'(exp_read(nsw, a, sz)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [11:0] a;
    logic [1:0]  sz;
    bit          nsw, w;
    r = $urandom(32'h5EC0_C7A1);
    for (int p = 0; p < NP; p++) begin m_ns[p] = 0; m_sp[p] = 0; m_nsp[p] = 0; end
    m_resp = 0; m_nsc = 0;
    bus_valid = 0; bus_write = 0; bus_nswin = 0; bus_addr = 0; bus_size = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    check_outputs("R1 reset");
    check("R12 idle rdata", W'(bus_rdata), W'(0));
    rd_check("R1 reset mask read", 0, 12'h074);
    rd_check("R1 reset nsp read", 1, 12'hC8);

    // R6 truncation, R5 nonsec follows
    wr(0, 12'h070, 32'hFFFF_FFFF);
    rd_check("R6 internal truncated", 0, 12'h070);
    check("R6 value", W'(m_ns[0]), W'(16'h000F));
    check_outputs("R5 internal nonsec");
    wr(0, 12'h084, 32'hFFFF_FFFF);
    rd_check("R6 expansion 16 bits", 0, 12'h084);

    // R2 and R4: three distinct masks on one controller
    wr(0, 12'h080, 32'h0000_A5A5);
    wr(0, 12'h0C0, 32'h0000_00FF);
    wr(1, 12'h0C0, 32'h0000_0F0F);
    check_outputs("R4 priv mux");
    rd_check("R2 sp readback", 0, 12'h0C0);
    rd_check("R3 nsp readback", 1, 12'h0C0);
    wr(0, 12'h06C, 32'h0000_8001);
    wr(0, 12'h0AC, 32'h0000_7FFE);
    check_outputs("R2 system-bus lane 9");
    wr(0, 12'h0B4, 32'h0000_0005);
    wr(1, 12'h0B4, 32'h0000_000A);
    check_outputs("R4 internal 1");

    // R3: mask writes via non-secure window ignored
    wr(1, 12'h080, 32'h0000_FFFF);
    wr(1, 12'h070, 32'h0000_0000);
    check_outputs("R3 ns window");
    rd_check("R3 ns window read zero", 1, 12'h080);
    rd_check("R3 secure unchanged", 0, 12'h080);

    // R7 configuration
    wr(0, 12'h010, 32'h0000_0003);
    wr(0, 12'h014, 32'h0000_00FE);
    check_outputs("R7 cfg set");
    wr(1, 12'h014, 32'h0000_0001);
    wr(1, 12'h010, 32'h0000_0000);
    check_outputs("R7 ns window cfg ignored");
    rd_check("R7 nsc read", 0, 12'h014);
    rd_check("R7 ns window cfg reads zero", 1, 12'h014);

    // R8 placeholders
    wr(0, 12'h050, 32'hFFFF_FFFF);
    wr(0, 12'h090, 32'hFFFF_FFFF);
    wr(1, 12'h090, 32'hFFFF_FFFF);
    check_outputs("R8 placeholder writes");
    rd_check("R8 0x50", 0, 12'h050);
    rd_check("R8 0x90 ns", 1, 12'h090);

    // R9 narrow writes
    wr(0, 12'h080, 32'h0, 2'd0);
    wr(0, 12'h080, 32'h0, 2'd1);
    wr(0, 12'h014, 32'h0, 2'd3);
    check_outputs("R9 narrow ignored");
    rd_check("R9 mask kept", 0, 12'h080);

    // R10 sub-word reads
    rd_check("R10 byte lane1", 0, 12'h081, 2'd0);
    rd_check("R10 byte lane0", 0, 12'h080, 2'd0);
    rd_check("R10 half upper", 0, 12'h082, 2'd1);
    rd_check("R10 half lower", 0, 12'h0AC, 2'd1);

    // R11 ID bytes
    rd_check("R11 part secure", 0, 12'hFE0);
    rd_check("R11 part nonsecure", 1, 12'hFE0);
    rd_check("R11 first", 0, 12'hFD0);
    rd_check("R11 last", 1, 12'hFFC);
    rd_check("R11 byte read", 0, 12'hFF4, 2'd0);

    // R12 unmapped
    wr(0, 12'h078, 32'hFFFF_FFFF);
    wr(0, 12'h200, 32'hFFFF_FFFF);
    check_outputs("R12 unmapped writes");
    rd_check("R12 unmapped 0x78", 0, 12'h078);
    rd_check("R12 unmapped 0x200", 0, 12'h200);

    // random traffic against the model (R2-R6, R9, R10)
    for (int n = 0; n < 800; n++) begin
      nsw = 1'($urandom);
      w   = 1'($urandom);
      sz  = ($urandom % 4 == 0) ? 2'($urandom) : 2'd2;
      if ($urandom % 8 == 0) a = 12'hFD0 + 12'($urandom % 48);
      else                   a = {4'h0, 8'($urandom)};
      if (w) begin
        wr(nsw, {a[11:2], 2'b00}, $urandom, sz);
        check_outputs("R4 R5 random write");
      end else begin
        rd_check("R10 random read", nsw, a, sz);
      end
    end

    finish_run();
  end

endmodule